// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block removes the DC offset from a two-channel stream of 24-bit audio samples. When its active-low reset is released, it spends a calibration window of word-clock frames measuring each channel. The window length depends on the speed mode. At the end of the window it stores the floor-rounded mean of the last power-of-two samples of each channel. From then on it subtracts that stored value from every raw sample and clamps the 25-bit difference back to 24 bits.

A calibration-busy flag covers the measuring phase. The corrected-data valid flag rises a fixed number of frames after the window closes. A select output tells the analog front end which source to present while the block is calibrating. A built-in word-clock interval monitor restarts the whole sequence by itself when the spacing between word-clock pulses changes. The restart needs no external reset.

The sample inputs are taken on each `wck_tick` pulse, which is one clock wide. All outputs except `zc_sel` are registered.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst_n` is low, `cal_busy` is 1, `out_valid` is 0 and both outputs read 0. These values appear asynchronously on the falling edge of `rst_n`.
- R2: `speed_sel` is latched on the first clock after reset release. Codes 00 and 11 select WIN_NORM ticks, 01 selects WIN_DBL and 10 selects WIN_QUAD. `cal_busy` falls in the cycle after the last tick of that window.
- R3: `out_valid` rises in the cycle after tick number window+VALID_LAG. It is never high together with `cal_busy`.
- R4: Each channel's offset is the arithmetic mean, rounded toward minus infinity, of its last 2^AVG_LOG2 raw samples of the window. Earlier samples of the window have no influence.
- R5: From tick window+VALID_LAG onward, each output updates one cycle after every tick to raw minus offset. Before that it reads 0. Between ticks it holds its value.
- R6: The difference is formed in 25 bits. Results above 0x7FFFFF are clamped to 0x7FFFFF, results below 0x800000 (two's complement) are clamped to 0x800000, and values exactly at these limits pass through unchanged.
- R7: From the third tick after reset, each interval between ticks (in clock cycles) is compared with the previous interval. When they differ, the next cycle shows `cal_busy` 1, `out_valid` 0 and both outputs 0. The mismatching tick is not counted, `speed_sel` is latched again on the following clock, and the sequence runs anew.
- R8: `zc_sel` equals `zc_cfg` while `cal_busy` is 1 and is 1 otherwise.
- R9: Changing `speed_sel` after it has been latched does not change the window length until the next reset or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset; release starts calibration |
| wck_tick | input | 1 | One-cycle pulse per word-clock rising edge |
| speed_sel | input | 2 | Speed mode: 00/11 normal, 01 double, 10 quad |
| zc_cfg | input | 1 | Calibration source choice driven onto `zc_sel` while busy |
| raw_l | input | DATA_W | Left raw sample, two's complement, taken on `wck_tick` |
| raw_r | input | DATA_W | Right raw sample, two's complement, taken on `wck_tick` |
| cal_busy | output | 1 | High while calibrating |
| zc_sel | output | 1 | Source select: 0 reference inputs, 1 signal inputs |
| out_l | output | DATA_W | Corrected left sample |
| out_r | output | DATA_W | Corrected right sample |
| out_valid | output | 1 | Corrected data valid |

## Verification
Every registered result (busy fall, valid rise, corrected data, restart clearing) is due exactly one clock after the posedge that takes the tick. The bench drives each tick at a falling edge and samples the outputs at the very next falling edge, after one register stage. The reset state is sampled 1 ns after `rst_n` falls, because that path is asynchronous. A restart shows in the sample taken right after the offending tick. The window length is then latched again on the next edge, which is well before the following tick.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
   typedef enum logic [1:0] {
      SPD_NORMAL = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10,
      SPD_RSVD   = 2'b11
   } speed_e;

   typedef enum logic {
      SQ_LATCH = 1'b0,
      SQ_RUN   = 1'b1
   } seq_state_e;
endpackage

// File: rtl/ocal_phase_det.sv
module ocal_phase_det #(
   parameter int IW = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic slip
);
   localparam logic [IW-1:0] ICNT_MAX = '1;

   logic [IW-1:0] icnt_q;
   logic [IW-1:0] ref_q;
   logic [1:0]    stage_q;

   // stage 0: no tick seen, 1: interval counting started, 2: reference held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         icnt_q  <= '0;
         ref_q   <= '0;
         stage_q <= 2'd0;
      end else begin
         if (tick)
            icnt_q <= IW'(1);
         else if (icnt_q != ICNT_MAX)
            icnt_q <= icnt_q + 1'b1;
         if (tick) begin
            if (stage_q != 2'd2) stage_q <= stage_q + 1'b1;
            if (stage_q != 2'd0) ref_q <= icnt_q;
         end
      end
   end

   assign slip = tick && (stage_q == 2'd2) && (icnt_q != ref_q);
endmodule

// File: rtl/ocal_chan.sv
module ocal_chan #(
   parameter int DW = 24,
   parameter int AW = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 acc_en,
   input  logic                 load_off,
   input  logic                 out_en,
   input  logic signed [DW-1:0] raw,
   output logic signed [DW-1:0] data
);
   localparam int SW = DW + AW;
   localparam int XW = DW + 1;
   localparam logic signed [XW-1:0] POS_LIM = {2'b00, {(DW-1){1'b1}}};
   localparam logic signed [XW-1:0] NEG_LIM = {2'b11, {(DW-1){1'b0}}};

   logic signed [SW-1:0] acc_q;
   logic signed [SW-1:0] acc_sum;
   logic signed [DW-1:0] off_q;
   logic signed [XW-1:0] diff;
   logic signed [DW-1:0] sat_val;

   always_comb begin
      acc_sum = acc_q + $signed({{AW{raw[DW-1]}}, raw});
      diff    = $signed({raw[DW-1], raw}) - $signed({off_q[DW-1], off_q});
      if (diff > POS_LIM)
         sat_val = POS_LIM[DW-1:0];
      else if (diff < NEG_LIM)
         sat_val = NEG_LIM[DW-1:0];
      else
         sat_val = diff[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         off_q <= '0;
         data  <= '0;
      end else if (clr) begin
         acc_q <= '0;
         off_q <= '0;
         data  <= '0;
      end else begin
         if (acc_en)   acc_q <= acc_sum;
         if (load_off) off_q <= DW'(acc_sum >>> AW);
         if (out_en)   data  <= sat_val;
      end
   end

   AST_DATA_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(out_en) && !$past(clr)) |-> $stable(data)); // R5
endmodule

// File: rtl/ocal_seq.sv
module ocal_seq
   import ocal_pkg::*;
#(
   parameter int WIN_NORM = 8704,
   parameter int WIN_DBL  = 17408,
   parameter int WIN_QUAD = 34816,
   parameter int LAG      = 15,
   parameter int AW       = 13
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  speed_e speed,
   input  logic   slip,
   output logic   busy,
   output logic   valid,
   output logic   clr,
   output logic   acc_en,
   output logic   load_off,
   output logic   out_en
);
   localparam int WMAX  = (WIN_QUAD > WIN_DBL) ?
                          ((WIN_QUAD > WIN_NORM) ? WIN_QUAD : WIN_NORM) :
                          ((WIN_DBL > WIN_NORM) ? WIN_DBL : WIN_NORM);
   localparam int CW    = $clog2(WMAX + LAG + 2);
   localparam int AVG_N = 2 ** AW;

   seq_state_e    st_q;
   logic [CW-1:0] win_q;
   logic [CW-1:0] fcnt_q;
   logic [CW-1:0] k_next;
   logic          run_tick;

   function automatic logic [CW-1:0] win_of(input speed_e s);
      case (s)
         SPD_DOUBLE: return CW'(WIN_DBL);
         SPD_QUAD:   return CW'(WIN_QUAD);
         default:    return CW'(WIN_NORM);
      endcase
   endfunction

   assign run_tick = tick && (st_q == SQ_RUN) && !slip;
   assign k_next   = fcnt_q + 1'b1;
   assign clr      = slip;
   assign acc_en   = run_tick && (int'(k_next) + AVG_N > int'(win_q)) &&
                     (int'(k_next) <= int'(win_q));
   assign load_off = run_tick && (k_next == win_q);
   assign out_en   = run_tick && (int'(k_next) >= int'(win_q) + LAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_LATCH;
         win_q  <= '0;
         fcnt_q <= '0;
         busy   <= 1'b1;
         valid  <= 1'b0;
      end else if (slip) begin
         st_q   <= SQ_LATCH;
         fcnt_q <= '0;
         busy   <= 1'b1;
         valid  <= 1'b0;
      end else if (st_q == SQ_LATCH) begin
         st_q  <= SQ_RUN;
         win_q <= win_of(speed);
      end else if (run_tick) begin
         if (int'(fcnt_q) < int'(win_q) + LAG) fcnt_q <= k_next;
         if (load_off) busy  <= 1'b0;
         if (out_en)   valid <= 1'b1;
      end
   end

   AST_VALID_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !busy); // R3
   AST_VALID_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(tick)); // R3
   AST_BUSY_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick)); // R2
   AST_RESTART_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      slip |=> (busy && !valid)); // R7
   AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SQ_RUN) && $past(st_q == SQ_RUN)) |-> $stable(win_q)); // R9
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
   import ocal_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int WIN_NORM = 8704,
   parameter int WIN_DBL  = 17408,
   parameter int WIN_QUAD = 34816,
   parameter int VALID_LAG = 15,
   parameter int AVG_LOG2 = 13,
   parameter int PHASE_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wck_tick,
   input  logic [1:0]               speed_sel,
   input  logic                     zc_cfg,
   input  logic signed [DATA_W-1:0] raw_l,
   input  logic signed [DATA_W-1:0] raw_r,
   output logic                     cal_busy,
   output logic                     zc_sel,
   output logic signed [DATA_W-1:0] out_l,
   output logic signed [DATA_W-1:0] out_r,
   output logic                     out_valid
);
   localparam int NCH   = 2;
   localparam int AVG_N = 2 ** AVG_LOG2;

   if (AVG_LOG2 < 1 || AVG_N > WIN_NORM || AVG_N > WIN_DBL || AVG_N > WIN_QUAD) begin : g_bad_avg
      $error("averaging span must be at least 2 and fit every window");
   end
   if (DATA_W < 2 || PHASE_W < 2 || VALID_LAG < 0) begin : g_bad_width
      $error("width or lag parameter out of range");
   end

   logic slip, clr, acc_en, load_off, out_en;
   logic signed [DATA_W-1:0] raw_a [NCH];
   logic signed [DATA_W-1:0] out_a [NCH];

   assign raw_a[0] = raw_l;
   assign raw_a[1] = raw_r;
   assign out_l    = out_a[0];
   assign out_r    = out_a[1];
   assign zc_sel   = cal_busy ? zc_cfg : 1'b1;

   ocal_phase_det #(.IW(PHASE_W)) u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (wck_tick),
      .slip (slip)
   );

   ocal_seq #(
      .WIN_NORM(WIN_NORM),
      .WIN_DBL (WIN_DBL),
      .WIN_QUAD(WIN_QUAD),
      .LAG     (VALID_LAG),
      .AW      (AVG_LOG2)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (wck_tick),
      .speed   (speed_e'(speed_sel)),
      .slip    (slip),
      .busy    (cal_busy),
      .valid   (out_valid),
      .clr     (clr),
      .acc_en  (acc_en),
      .load_off(load_off),
      .out_en  (out_en)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ocal_chan #(.DW(DATA_W), .AW(AVG_LOG2)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .acc_en  (acc_en),
         .load_off(load_off),
         .out_en  (out_en),
         .raw     (raw_a[c]),
         .data    (out_a[c])
      );
   end
endmodule

// File: tb/test_offset_cal_seq.sv
`timescale 1ns/1ps
module test_offset_cal_seq;
   localparam int WN = 40, WD = 56, WQ = 72, LAG = 5, AL = 4, NAVG = 16;
   localparam int PMAX = 8388607, NMIN = -8388608;

   logic clk = 0, rst_n = 0, wck_tick = 0, zc_cfg = 0;
   logic [1:0] speed_sel = 2'b00;
   logic signed [23:0] raw_l = '0, raw_r = '0;
   logic cal_busy, zc_sel, out_valid;
   logic signed [23:0] out_l, out_r;

   int total = 0, bad = 0;
   int k, w_cur, ph_stage, ph_ref, prev_gap, offl, offr, e_l, e_r;
   longint suml, sumr;
   bit e_busy, e_valid;

   always #2 clk = ~clk;

   offset_cal_seq #(.DATA_W(24), .WIN_NORM(WN), .WIN_DBL(WD), .WIN_QUAD(WQ),
                    .VALID_LAG(LAG), .AVG_LOG2(AL), .PHASE_W(8)) i_offset_cal_seq (
      .clk(clk), .rst_n(rst_n), .wck_tick(wck_tick), .speed_sel(speed_sel),
      .zc_cfg(zc_cfg), .raw_l(raw_l), .raw_r(raw_r), .cal_busy(cal_busy),
      .zc_sel(zc_sel), .out_l(out_l), .out_r(out_r), .out_valid(out_valid));

   function automatic int win_of(input logic [1:0] s);
      if (s == 2'b01) return WD;
      if (s == 2'b10) return WQ;
      return WN;
   endfunction

   function automatic int sat24(input int v);
      if (v > PMAX) return PMAX;
      if (v < NMIN) return NMIN;
      return v;
   endfunction

   function automatic int rnd24();
      return int'($urandom_range(16777215)) - 8388608;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic seq_clear();
      k = 0; suml = 0; sumr = 0; offl = 0; offr = 0;
      e_busy = 1; e_valid = 0; e_l = 0; e_r = 0;
   endtask

   task automatic do_reset(input logic [1:0] spd, input logic cfg);
      rst_n = 0; wck_tick = 0; speed_sel = spd; zc_cfg = cfg;
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", int'(cal_busy), 1);
      check("R1", "valid in reset", int'(out_valid), 0);
      check("R1", "left in reset", int'(out_l), 0);
      check("R1", "right in reset", int'(out_r), 0);
      check("R8", "zc_sel in reset", int'(zc_sel), int'(cfg));
      rst_n = 1;
      seq_clear();
      w_cur = win_of(spd); ph_stage = 0; ph_ref = 0; prev_gap = 0;
      repeat (2) @(negedge clk);
   endtask

   // one word-clock frame: tick now, next tick after gap cycles
   task automatic do_tick(input int gap, input int l, input int r, input string btag, input string dtag);
      bit restart = 0;
      string bt = btag, dt = dtag;
      if (ph_stage == 0) ph_stage = 1;
      else if (ph_stage == 1) begin ph_ref = prev_gap; ph_stage = 2; end
      else begin
         if (prev_gap != ph_ref) restart = 1;
         ph_ref = prev_gap;
      end
      wck_tick = 1; raw_l = l[23:0]; raw_r = r[23:0];
      @(negedge clk);
      wck_tick = 0;
      if (restart) begin
         seq_clear();
         w_cur = win_of(speed_sel);
         bt = "R7"; dt = "R7";
      end else begin
         k++;
         if (k > w_cur - NAVG && k <= w_cur) begin suml += l; sumr += r; end
         if (k == w_cur) begin offl = int'(suml >>> AL); offr = int'(sumr >>> AL); end
         e_busy  = (k < w_cur);
         e_valid = (k >= w_cur + LAG);
         if (e_valid) begin e_l = sat24(l - offl); e_r = sat24(r - offr); end
      end
      check(bt, "busy", int'(cal_busy), int'(e_busy));
      check(restart ? "R7" : "R3", "valid", int'(out_valid), int'(e_valid));
      check(dt, "left data", int'(out_l), e_l);
      check(dt, "right data", int'(out_r), e_r);
      check("R8", "zc_sel", int'(zc_sel), e_busy ? int'(zc_cfg) : 1);
      repeat (gap - 1) @(negedge clk);
      prev_gap = gap;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lv, rv;
      void'($urandom(32'd2718));
      // A: normal mode, early samples far off, mode change mid-window (R4, R9)
      do_reset(2'b00, 1'b0);
      for (int i = 1; i <= WN + LAG + 6; i++) begin
         if (i <= WN - NAVG) begin
            lv = 3000000 + int'($urandom_range(999));
            rv = -3000000 - int'($urandom_range(999));
         end else if (i <= WN) begin
            lv = 1200 + int'($urandom_range(63));
            rv = -5000 - int'($urandom_range(63));
         end else begin
            lv = rnd24(); rv = rnd24();
         end
         if (i == 20) speed_sel = 2'b10;
         do_tick(4, lv, rv, "R9", "R4");
      end
      // B: interval change restarts the sequence (R7), new mode latched
      speed_sel = 2'b01;
      do_tick(6, rnd24(), rnd24(), "R7", "R5");
      for (int i = 0; i < WD + LAG + 4; i++)
         do_tick(6, (i % 7) * 1000 - 2500, 700 - (i % 5) * 333, "R7", "R7");
      // C: asynchronous reset mid-stream (R1)
      #1 rst_n = 0;
      #1;
      check("R1", "busy at reset edge", int'(cal_busy), 1);
      check("R1", "valid at reset edge", int'(out_valid), 0);
      check("R1", "left at reset edge", int'(out_l), 0);
      @(negedge clk);
      // D: reserved code behaves as normal; saturation in both directions (R6)
      do_reset(2'b11, 1'b1);
      for (int i = 1; i <= WN + LAG + 8; i++) begin
         if (i <= WN) begin lv = -7340032; rv = 7340032; end
         else begin
            case (i - WN)
               1: begin lv = 1048575;  rv = -1048576; end
               2: begin lv = 1048576;  rv = -1048577; end
               3: begin lv = NMIN;     rv = PMAX;     end
               4: begin lv = PMAX;     rv = NMIN;     end
               5: begin lv = 1048575;  rv = -1048576; end
               6: begin lv = 1048576;  rv = -1048577; end
               7: begin lv = 0;        rv = 0;        end
               default: begin lv = PMAX; rv = NMIN;   end
            endcase
         end
         do_tick(4, lv, rv, "R2", "R6");
      end
      // E: quad mode with random full-range data (R2, R5)
      do_reset(2'b10, 1'b0);
      for (int i = 1; i <= WQ + LAG + 10; i++)
         do_tick(5, rnd24(), rnd24(), "R2", "R5");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule